// File: doc/BRIEF.md
# NVM Checksum Validate and Update Engine

This block walks the leading region of a word-organised nonvolatile memory through a simple request/acknowledge word port. It either confirms that the region carries a valid checksum or rewrites the checksum word so that the region becomes valid. The checksum rule is signature-based. The wrapping 16-bit sum of every word from address 0 through the checksum word must equal the constant 0xBABA. It does not have to be zero.

A host starts an operation with a one-cycle command strobe and a mode bit. The engine then issues reads one at a time, each held until the memory acknowledges it, and adds each returned word into a 16-bit accumulator.

In validate mode the accumulator is compared against the signature after the checksum word itself is added. In update mode the engine stops reading one word short of the checksum word and writes the signature minus the partial sum to it. A memory error on any access ends the operation immediately. The result is a one-cycle completion pulse with a status code.

Top module: `nvm_csum_engine`

## Requirements
- R1: In validate mode (cmd_update=0) the engine reads addresses 0, 1, 2, ... CSUM_IDX in ascending order, with never more than one request outstanding. It reports status 2'b00 (pass) exactly when the 16-bit sum of those words equals 0xBABA.
- R2: A validate whose sum differs from 0xBABA reports status 2'b01 (mismatch).
- R3: The sum wraps modulo 2^16: carries out of bit 15 are discarded.
- R4: In update mode (cmd_update=1) the engine reads addresses 0 through CSUM_IDX-1. It then issues one write to address CSUM_IDX with data 0xBABA minus the sum, modulo 2^16, and reports status 2'b00 when that write is acknowledged without error.
- R5: A read acknowledged with mem_err high ends the operation at once. No further request is issued, and done is raised in the next cycle with status 2'b10 (memory error).
- R6: A write acknowledged with mem_err high reports status 2'b10.
- R7: done is a single-cycle pulse. status keeps its value until the next operation completes. busy is high from the cycle after a command is accepted until done.
- R8: cmd_valid is ignored while an operation is running. It neither restarts nor changes the mode of that operation.
- R9: mem_req, once raised, stays high with mem_addr, mem_we and mem_wdata unchanged until the cycle in which mem_ack is high.
- R10: A validate operation never issues a write.
- R11: After reset, busy, done and mem_req are low and status is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted only when idle |
| cmd_update | input | 1 | Mode: 0 validate, 1 update |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 pass, 01 mismatch, 10 memory error |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed, valid with mem_ack |

## Verification
The bench targets region sums that overflow 16 bits many times over. An engine that saturated or kept a wider sum would then flag valid images as mismatched or write the wrong correction. Errors are injected on the first word, on a middle word, on the checksum word during a read, and on the update's write. A design that kept reading after a failure, or read one word too far in update mode, shows up in the acknowledge count and the status. A second command strobe sent mid-operation shows whether the engine wrongly restarts or switches to writing. Each update is followed by a validate to confirm that the written value actually closes the sum.

// File: rtl/nvm_csum_pkg.sv
package nvm_csum_pkg;

  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] CSUM_SIG = 16'hBABA;

  typedef enum logic [1:0] {
    ST_PASS     = 2'b00,
    ST_MISMATCH = 2'b01,
    ST_MEMERR   = 2'b10
  } csum_status_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_READ,
    PH_WRITE,
    PH_DONE
  } csum_phase_e;

  // Wrapping sum step.
  function automatic logic [WORD_W-1:0] csum_add(input logic [WORD_W-1:0] acc,
                                                 input logic [WORD_W-1:0] word);
    return acc + word;
  endfunction

  // Value that makes the region total equal the signature.
  function automatic logic [WORD_W-1:0] csum_fix(input logic [WORD_W-1:0] partial);
    return CSUM_SIG - partial;
  endfunction

endpackage

// File: rtl/csum_accum.sv
module csum_accum
  import nvm_csum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] sum
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum <= '0;
    else if (clr)    sum <= '0;
    else if (add_en) sum <= csum_add(sum, word);
  end

endmodule

// File: rtl/csum_walker.sv
module csum_walker #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [ADDR_W-1:0] last,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (clr)  addr <= '0;
    else if (step) addr <= addr + ADDR_W'(1);
  end

  assign at_last = (addr == last);

endmodule

// File: rtl/nvm_csum_engine.sv
module nvm_csum_engine
  import nvm_csum_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CSUM_IDX = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_update,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);

  localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(CSUM_IDX);
  localparam logic [ADDR_W-1:0] LAST_U = ADDR_W'(CSUM_IDX - 1);

  csum_phase_e     phase;
  csum_status_e    stat_q;
  logic            op_upd;
  logic [15:0]     sum;
  logic [ADDR_W-1:0] rd_addr;
  logic            at_last;

  // Named internal events, shared with the checker.
  logic start, rd_beat, wr_beat, rd_ok;
  assign start   = (phase == PH_IDLE) && cmd_valid;
  assign rd_beat = (phase == PH_READ) && mem_ack;
  assign wr_beat = (phase == PH_WRITE) && mem_ack;
  assign rd_ok   = rd_beat && !mem_err;

  csum_accum u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start),
    .add_en (rd_ok),
    .word   (mem_rdata),
    .sum    (sum)
  );

  csum_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .step    (rd_ok),
    .last    (op_upd ? LAST_U : LAST_V),
    .addr    (rd_addr),
    .at_last (at_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      stat_q <= ST_PASS;
      op_upd <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (cmd_valid) begin
          op_upd <= cmd_update;
          phase  <= PH_READ;
        end
        PH_READ: if (mem_ack) begin
          if (mem_err) begin
            stat_q <= ST_MEMERR;
            phase  <= PH_DONE;
          end else if (at_last) begin
            if (op_upd) begin
              phase <= PH_WRITE;
            end else begin
              stat_q <= (csum_add(sum, mem_rdata) == CSUM_SIG) ? ST_PASS : ST_MISMATCH;
              phase  <= PH_DONE;
            end
          end
        end
        PH_WRITE: if (mem_ack) begin
          stat_q <= mem_err ? ST_MEMERR : ST_PASS;
          phase  <= PH_DONE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (phase == PH_READ) || (phase == PH_WRITE);
  assign done      = (phase == PH_DONE);
  assign status    = stat_q;
  assign mem_req   = busy;
  assign mem_we    = (phase == PH_WRITE);
  assign mem_addr  = mem_we ? LAST_V : rd_addr;
  assign mem_wdata = mem_we ? csum_fix(sum) : '0;

endmodule

// File: rtl/csum_engine_checker.sv
module csum_engine_checker #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CSUM_IDX = 63
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [1:0]        status,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              op_upd,
  input logic              rd_beat
);

  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(CSUM_IDX);

  assert_ascending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat && !mem_err |=> (!mem_req || mem_we || mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr <= LAST_A);

  assert_write_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr == LAST_A);

  assert_err_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat && mem_err |=> done && status == 2'b10 && !mem_req);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_no_write_validate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> op_upd);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

endmodule

bind nvm_csum_engine csum_engine_checker #(.ADDR_W(ADDR_W), .CSUM_IDX(CSUM_IDX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .status    (status),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .mem_err   (mem_err),
  .op_upd    (op_upd),
  .rd_beat   (rd_beat)
);

// File: tb/tb_nvm_csum_engine.sv
`timescale 1ns/1ps
module tb_nvm_csum_engine;

  localparam int AW   = 8;
  localparam int LAST = 63;
  localparam int SIG  = 47802; // 0xBABA

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_update = 0;
  logic busy, done, mem_req, mem_we;
  logic [1:0] status;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic mem_ack, mem_err;

  always #2 clk = ~clk;

  nvm_csum_engine #(.ADDR_W(AW), .CSUM_IDX(LAST)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_update(cmd_update),
    .busy(busy), .done(done), .status(status), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_err(mem_err)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] mem [0:LAST];
  int lat = 0, wcnt = 0, acks = 0, dones = 0;
  bit err_en = 0;
  int err_at = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: acks after lat idle cycles; writes land on ack.
  initial begin
    mem_ack = 0; mem_err = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      mem_ack = 0; mem_err = 0; mem_rdata = 0;
      if (done) dones++;
      if (mem_req) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0; mem_ack = 1; acks++;
          if (err_en && int'(mem_addr) == err_at) mem_err = 1;
          else if (mem_we) mem[mem_addr] = mem_wdata;
          else mem_rdata = mem[mem_addr];
        end
      end
    end
  end

  function automatic logic [15:0] word_of(input int i, input logic [15:0] seed);
    if (seed == 0) return 16'hFFFF;
    return 16'((int'(seed) * (i + 1)) ^ (i * 8));
  endfunction

  function automatic int total(input int upto);
    int s = 0;
    for (int i = 0; i <= upto; i++) s = (s + int'(mem[i])) % 65536;
    return s;
  endfunction

  task automatic run(input bit upd);
    acks = 0;
    @(negedge clk); cmd_valid = 1; cmd_update = upd;
    @(negedge clk); cmd_valid = 0;
    while (!done) @(negedge clk);
  endtask

  typedef struct packed {
    logic        upd;
    logic [15:0] seed;
    logic [1:0]  lat;
    logic        good;
    logic        err_en;
    logic [7:0]  err_at;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 16'h0137, 2'd0, 1'b1, 1'b0, 8'd0 },  // R1 pass
    '{1'b0, 16'h0137, 2'd1, 1'b0, 1'b0, 8'd0 },  // R2 mismatch
    '{1'b0, 16'h0000, 2'd2, 1'b1, 1'b0, 8'd0 },  // R3 all 0xFFFF
    '{1'b1, 16'hF00D, 2'd0, 1'b0, 1'b0, 8'd0 },  // R4 update
    '{1'b1, 16'h0000, 2'd3, 1'b0, 1'b0, 8'd0 },  // R3/R4 update wrap
    '{1'b0, 16'h2222, 2'd0, 1'b1, 1'b1, 8'd17},  // R5 mid read error
    '{1'b1, 16'h5A5A, 2'd1, 1'b0, 1'b1, 8'd0 },  // R5 first read error
    '{1'b1, 16'h7777, 2'd0, 1'b0, 1'b1, 8'd63},  // R6 write error
    '{1'b0, 16'h3333, 2'd2, 1'b1, 1'b1, 8'd63}   // R5 error on checksum word
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int exp_st, exp_acks, exp_w, s, keep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !mem_req && status == 2'b00, "R11 reset state",
          {busy, done, mem_req, status}, 0);

    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      for (int i = 0; i <= LAST; i++) mem[i] = word_of(i, v.seed);
      if (!v.upd) begin
        s = total(LAST - 1);
        mem[LAST] = 16'((SIG - s + 65536) % 65536 + (v.good ? 0 : 1));
      end else mem[LAST] = 16'h1234;
      lat = int'(v.lat); err_en = v.err_en; err_at = int'(v.err_at);
      exp_w = (SIG - total(LAST - 1) + 65536) % 65536;
      keep = int'(mem[LAST]);
      exp_st = v.err_en ? 2 : (v.upd ? 0 : (v.good ? 0 : 1));
      exp_acks = v.err_en ? int'(v.err_at) + 1 : LAST + 1;
      run(v.upd);
      check(int'(status) == exp_st, v.upd ? "R4/R5/R6 status" : "R1/R2/R3/R5 status",
            int'(status), exp_st);
      check(acks == exp_acks, "R1/R4/R5 access count", acks, exp_acks);
      @(negedge clk);
      check(!done && !mem_req, "R5/R7 done pulse then quiet", {done, mem_req}, 0);
      if (v.upd && !v.err_en) begin
        check(int'(mem[LAST]) == exp_w, "R4 written checksum", int'(mem[LAST]), exp_w);
        err_en = 0;
        run(1'b0);
        check(status == 2'b00, "R4 validate after update", int'(status), 0);
      end else if (!v.upd) begin
        check(int'(mem[LAST]) == keep, "R10 no write in validate", int'(mem[LAST]), keep);
      end
      err_en = 0;
    end

    // R8: strobe with update mode during a running validate.
    for (int i = 0; i <= LAST; i++) mem[i] = word_of(i, 16'h0F0F);
    mem[LAST] = 16'h1111;
    lat = 1; dones = 0; acks = 0;
    @(negedge clk); cmd_valid = 1; cmd_update = 0;
    @(negedge clk); cmd_valid = 0;
    repeat (5) @(negedge clk);
    check(busy, "R7 busy during operation", busy, 1);
    cmd_valid = 1; cmd_update = 1;
    @(negedge clk); cmd_valid = 0;
    while (!done) @(negedge clk);
    check(acks == LAST + 1, "R8 no restart", acks, LAST + 1);
    check(mem[LAST] == 16'h1111, "R8 mode unchanged", int'(mem[LAST]), 16'h1111);
    exp_st = (total(LAST) == SIG) ? 0 : 1;
    check(int'(status) == exp_st, "R8 status", int'(status), exp_st);
    repeat (4) @(negedge clk);
    check(dones == 1 && !busy, "R8 single completion", dones, 1);
    check(int'(status) == exp_st, "R7 status held", int'(status), exp_st);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule